// File: doc/BRIEF.md
# Sample Capture Buffer with Overrun Detection

This block sits between a digital input sampler and a downstream data mover. Each time the sample strobe fires, the word on the sample input is written into an internal first-in first-out store. The drain side needs no command to start. Whenever at least one word is held, the block raises its drain valid signal with the oldest word on the drain data output. The downstream mover takes that word on any cycle where it also drives ready. The two sides run at independent rates but share one clock.

The sampler cannot be stalled, so the block never pushes back on it. A strobe that arrives while every slot is occupied, with no drain transfer in that same cycle, loses its word. That loss sets a sticky overrun flag. The flag stays up until host logic pulses the clear input. A clear that coincides with a fresh loss does not win, so no loss goes unreported. An occupancy output gives the current number of stored words. A synchronous reset empties the store and lowers the flag. The depth is a parameter. The full-size build uses 16384 entries of 16 bits, which gives a 15-bit occupancy output.

Top module: `capture_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `occupancy` = 0, `drn_valid` = 0 and `ovr_flag` = 0, regardless of prior content or flag state.
- R2: A cycle with `smp_stb` = 1 and `occupancy` < DEPTH stores `smp_data`, and `occupancy` rises by one after the edge, unless a drain transfer happens in the same cycle.
- R3: Words leave on `drn_data` in the order they were stored, and `drn_data` holds still while `drn_valid` = 1 and `drn_ready` = 0.
- R4: `drn_valid` is 1 exactly when `occupancy` is non-zero. A transfer happens only on a cycle with `drn_valid` = 1 and `drn_ready` = 1, and it lowers `occupancy` by one when no word is stored in the same cycle. `drn_ready` while empty has no effect.
- R5: A strobe with `occupancy` = DEPTH and no drain transfer in that cycle discards its word. `occupancy` stays at DEPTH, and that word never appears on `drn_data`. The first strobe after space frees up is stored normally.
- R6: A discarded sample sets `ovr_flag` = 1 from the next cycle. The flag never rises without a discarded sample.
- R7: `ovr_flag` stays 1 until a cycle with `ovr_clr` = 1 and no discard, after which it reads 0. A clear in the same cycle as a discard leaves the flag at 1.
- R8: A strobe and a drain transfer in the same cycle while full are both accepted. `occupancy` stays at DEPTH, the flag does not rise, and the new word is later delivered after the words already held.
- R9: A strobe and a drain transfer in the same cycle while neither empty nor full leave `occupancy` unchanged. A strobe with `drn_ready` = 1 while empty only stores the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by sampler and drain |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one word per high cycle |
| smp_data | input | DATA_W | Sampled input word |
| drn_valid | output | 1 | Oldest stored word is available |
| drn_ready | input | 1 | Downstream accepts the offered word |
| drn_data | output | DATA_W | Oldest stored word |
| occupancy | output | $clog2(DEPTH+1) | Number of stored words |
| ovr_flag | output | 1 | Sticky record of a discarded sample |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |

## Verification
Several properties are checked on every cycle: the occupancy bound and its exact step from strobe and transfer, the match between valid and non-zero occupancy, the stable head word while the drain stalls, and the set, hold, clear and clear-loses-to-loss rules of the overrun flag. Word ordering across wrap-around cannot be shown that way. The same holds for the proof that a discarded word never surfaces, and for the order of the word accepted during a full-with-transfer cycle. Those come only from the bench's scripted sequence, which compares every head word against the expected stream.

// File: rtl/cap_pkg.sv
package cap_pkg;

    // Operation chosen for the storage control in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } cap_op_e;

    // Per-cycle decision carried from the accept logic
    typedef struct packed {
        logic push;   // sample stored this cycle
        logic pop;    // head word handed to the drain
        logic drop;   // sample lost for lack of space
    } cap_dec_t;

    // Next slot index with wrap at the last slot
    function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

    function automatic cap_op_e op_of(cap_dec_t d);
        return cap_op_e'({d.pop, d.push});
    endfunction

endpackage

// File: rtl/cap_store.sv
module cap_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          rdy,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          valid,
    output logic          drop
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    cap_dec_t dec;
    logic     full;

    assign full  = (count == FULL_CNT);
    assign valid = (count != '0);

    always_comb begin
        dec.pop  = valid & rdy;
        // a pop in the same cycle frees the slot the new word needs
        dec.push = stb & (~full | dec.pop);
        dec.drop = stb & full & ~dec.pop;
    end

    assign wr_en = dec.push;
    assign drop  = dec.drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (dec.push) begin
                wr_ptr <= AW'(wrap_next(32'(wr_ptr), DEPTH));
            end
            if (dec.pop) begin
                rd_ptr <= AW'(wrap_next(32'(rd_ptr), DEPTH));
            end
            case (op_of(dec))
                OP_PUSH: count <= count + 1'b1;
                OP_POP:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cap_ovr.sv
module cap_ovr (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (drop) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/capture_fifo.sv
module capture_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_stb,
    input  logic [DATA_W-1:0]          smp_data,
    output logic                       drn_valid,
    input  logic                       drn_ready,
    output logic [DATA_W-1:0]          drn_data,
    output logic [$clog2(DEPTH+1)-1:0] occupancy,
    output logic                       ovr_flag,
    input  logic                       ovr_clr
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          drop;

    cap_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .stb    (smp_stb),
        .rdy    (drn_ready),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (occupancy),
        .valid  (drn_valid),
        .drop   (drop)
    );

    cap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (smp_data),
        .raddr (rd_ptr),
        .rdata (drn_data)
    );

    cap_ovr u_ovr (
        .clk  (clk),
        .rst  (rst),
        .drop (drop),
        .clr  (ovr_clr),
        .flag (ovr_flag)
    );

endmodule

// File: rtl/capture_fifo_chk.sv
module capture_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       smp_stb,
    input logic                       drn_valid,
    input logic                       drn_ready,
    input logic [DATA_W-1:0]          drn_data,
    input logic [$clog2(DEPTH+1)-1:0] occupancy,
    input logic                       ovr_flag,
    input logic                       ovr_clr
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic xfer, lost, stored;
    assign xfer   = drn_valid & drn_ready;
    assign lost   = smp_stb & (occupancy == FULLV) & ~xfer;
    assign stored = smp_stb & ~lost;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (occupancy == '0) && !drn_valid && !ovr_flag);

    assert_bound_R2: assert property (@(posedge clk) disable iff (rst)
        occupancy <= FULLV);

    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> occupancy == CW'($past(occupancy) + CW'($past(stored)) - CW'($past(xfer))));

    assert_valid_R4: assert property (@(posedge clk) disable iff (rst)
        drn_valid == (occupancy != '0));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        drn_valid && !drn_ready |=> $stable(drn_data) && drn_valid);

    assert_ovr_set_R6: assert property (@(posedge clk) disable iff (rst)
        lost |=> ovr_flag);

    assert_ovr_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(lost));

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr_flag && !ovr_clr |=> ovr_flag);

    assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ovr_clr && !lost |=> !ovr_flag);

    assert_full_both_R8: assert property (@(posedge clk) disable iff (rst)
        smp_stb && xfer && (occupancy == FULLV) |=> (occupancy == FULLV));

endmodule

bind capture_fifo capture_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_stb   (smp_stb),
    .drn_valid (drn_valid),
    .drn_ready (drn_ready),
    .drn_data  (drn_data),
    .occupancy (occupancy),
    .ovr_flag  (ovr_flag),
    .ovr_clr   (ovr_clr)
);

// File: tb/test_capture_fifo.sv
module test_capture_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int DEP = 4;
    localparam int CW  = $clog2(DEP + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          smp_stb;
    logic [DW-1:0] smp_data;
    logic          drn_valid;
    logic          drn_ready;
    logic [DW-1:0] drn_data;
    logic [CW-1:0] occupancy;
    logic          ovr_flag;
    logic          ovr_clr;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    capture_fifo #(.DATA_W(DW), .DEPTH(DEP)) i_capture_fifo (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .smp_data  (smp_data),
        .drn_valid (drn_valid),
        .drn_ready (drn_ready),
        .drn_data  (drn_data),
        .occupancy (occupancy),
        .ovr_flag  (ovr_flag),
        .ovr_clr   (ovr_clr)
    );

    typedef struct packed {
        logic          stb;
        logic [DW-1:0] data;
        logic          rdy;
        logic          clr;
        logic [CW-1:0] cnt;   // expected after the edge
        logic          ovr;
        logic          vld;
        logic [DW-1:0] head;
        logic [3:0]    req;   // requirement exercised, for messages
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'hA001, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA001, 4'd2},
        '{1'b1, 16'hA002, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 16'hA001, 4'd2},
        '{1'b1, 16'hA003, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 16'hA001, 4'd3},
        '{1'b1, 16'hA004, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 16'hA001, 4'd2},
        '{1'b1, 16'hA005, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1, 16'hA001, 4'd5},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1, 16'hA001, 4'd7},
        '{1'b1, 16'hA006, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 16'hA002, 4'd8},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 16'hA003, 4'd4},
        '{1'b1, 16'hA007, 1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 16'hA003, 4'd7},
        '{1'b1, 16'hA008, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 16'hA003, 4'd7},
        '{1'b0, 16'h0000, 1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 16'hA003, 4'd7},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 16'hA004, 4'd3},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 16'hA006, 4'd8},
        '{1'b1, 16'hA009, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 16'hA007, 4'd9},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA009, 4'd5},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 4'd4},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 4'd4},
        '{1'b1, 16'hA00A, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA00A, 4'd9},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 4'd4}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic stb, input logic [DW-1:0] d,
                        input logic rdy, input logic clr);
        @(negedge clk);
        smp_stb   = stb;
        smp_data  = d;
        drn_ready = rdy;
        ovr_clr   = clr;
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic check_idle(input string req);
        check(req, "occupancy", 32'(occupancy), 32'd0);
        check(req, "drn_valid", 32'(drn_valid), 32'd0);
        check(req, "ovr_flag",  32'(ovr_flag),  32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; smp_stb = 1'b0; smp_data = '0; drn_ready = 1'b0; ovr_clr = 1'b0;
        step(1'b0, '0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check_idle("R1");
        @(negedge clk);
        rst = 1'b0;

        // Table walk: fill, discard, sticky flag, clear rules, full with transfer, drain
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            step(VECS[i].stb, VECS[i].data, VECS[i].rdy, VECS[i].clr);
            check(tag, $sformatf("v%0d occupancy", i), 32'(occupancy), 32'(VECS[i].cnt));
            check(tag, $sformatf("v%0d ovr_flag", i),  32'(ovr_flag),  32'(VECS[i].ovr));
            check(tag, $sformatf("v%0d drn_valid", i), 32'(drn_valid), 32'(VECS[i].vld));
            if (VECS[i].vld) begin
                check(tag, $sformatf("v%0d drn_data", i), 32'(drn_data), 32'(VECS[i].head));
            end
        end

        // R5: after the first discard, capture resumes with the next strobe once space frees up
        step(1'b1, 16'hB001, 1'b0, 1'b0);
        step(1'b1, 16'hB002, 1'b0, 1'b0);
        step(1'b1, 16'hB003, 1'b0, 1'b0);
        step(1'b1, 16'hB004, 1'b0, 1'b0);
        step(1'b1, 16'hB0FF, 1'b0, 1'b0);
        check("R5", "occupancy full after discard", 32'(occupancy), 32'd4);
        check("R6", "flag after discard", 32'(ovr_flag), 32'd1);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, 16'hB005, 1'b0, 1'b0);
        check("R5", "resumed store", 32'(occupancy), 32'd4);
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] want;
            want = 16'hB002 + DW'(k);
            check("R5", $sformatf("drain order %0d", k), 32'(drn_data), 32'(want));
            step(1'b0, '0, 1'b1, 1'b0);
        end
        check("R4", "empty after drain", 32'(drn_valid), 32'd0);

        // R3: stalled drain holds head word while new words arrive
        step(1'b1, 16'hC001, 1'b0, 1'b0);
        step(1'b1, 16'hC002, 1'b0, 1'b0);
        check("R3", "head held under stall", 32'(drn_data), 32'hC001);

        // R1: reset in the middle of a run with content and flag set
        step(1'b1, 16'hC003, 1'b0, 1'b0);
        step(1'b1, 16'hC004, 1'b0, 1'b0);
        step(1'b1, 16'hC005, 1'b0, 1'b0);
        check("R6", "flag before reset", 32'(ovr_flag), 32'd1);
        @(negedge clk);
        rst = 1'b1;
        step(1'b0, '0, 1'b0, 1'b0);
        check_idle("R1");
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, '0, 1'b1, 1'b0);
        check("R4", "ready while empty after reset", 32'(occupancy), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule